// File: doc/BRIEF.md
# Dual-Modulus Pulse Divider

This block counts single-cycle enable pulses arriving in the system clock domain and divides them by one of two moduli fixed at build time: a lower modulus `P` and an upper modulus `P+M` (default 10 and 11). A mode input selects the modulus. The block emits a single-cycle strobe each time a division cycle completes. A chain of slower programmable counters can then use that strobe to steer the mode and reach any overall ratio.

The mode input is sampled only at a cycle boundary. That is the clock edge on which the pulse that completes a cycle is accepted. The sampled value sets the length of the cycle that follows. A change made at any other time, whether on a non-final pulse or on an idle clock, cannot stretch or shorten the cycle in progress. After reset the first cycle uses the upper modulus.

Top module: `dual_modulus_divider`

## Requirements
- R1: When the captured mode is low (0), a division cycle spans exactly `P` input pulses.
- R2: When the captured mode is high (1), a division cycle spans exactly `P+M` input pulses.
- R3: `cycle_o` goes high for exactly one clock, on the clock after the edge that accepts the final pulse of a cycle. It is low at all other times.
- R4: `mode_hi_i` is sampled only on the edge that accepts the final pulse of a cycle, and it sets the length of the next cycle. Its value on any other edge, with or without a pulse, has no effect on any cycle length.
- R5: Synchronous active-high reset clears the pulse count, holds `cycle_o` low and selects the upper modulus (`P+M`) for the first cycle.
- R6: Clocks with `pulse_i` low do not advance the count. Idle gaps of any length between pulses leave cycle lengths unchanged.
- R7: Reset asserted partway through a cycle discards the pulses already counted. The next cycle again spans `P+M` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_i | input | 1 | Single-cycle input pulse to be divided |
| mode_hi_i | input | 1 | Modulus select: 1 picks P+M, 0 picks P |
| cycle_o | output | 1 | Single-cycle strobe, one per completed cycle |

## Verification
On every cycle the in-line assertions check several properties. The count stays below the active modulus and holds still on idle clocks. The captured mode moves only at a cycle boundary. The strobe follows every boundary and lasts one clock, and reset leaves the documented state. Only the bench scenarios can show the actual cycle lengths. Those scenarios cover a mode held low or high, a mode toggled on every pulse and during idle gaps, irregular pulse spacing, and a reset that lands mid-cycle.

// File: rtl/dual_modulus_divider.sv
module dual_modulus_divider #(
  parameter int P = 10,
  parameter int M = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic mode_hi_i,
  output logic cycle_o
);
  localparam int HI = P + M;
  localparam int CW = $clog2(HI + 1);

  logic [CW-1:0] cnt;
  logic          hi_q;
  logic          strobe_q;
  logic [CW-1:0] cur_mod;
  logic          last;
  logic          boundary;

  assign cur_mod  = hi_q ? CW'(HI) : CW'(P);
  assign last     = (cnt == cur_mod - CW'(1));
  assign boundary = pulse_i && last;
  assign cycle_o  = strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      hi_q     <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= boundary;
      if (pulse_i) begin
        if (last) begin
          cnt  <= '0;
          hi_q <= mode_hi_i;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R1 R2: count never reaches the active modulus
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_mod);

  // R6: idle clocks leave the count alone
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |=> $stable(cnt));

  // R4: captured mode only moves on a boundary
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(hi_q));

  // R3: strobe follows each boundary
  p_strobe_after_r3: assert property (@(posedge clk) disable iff (rst)
    boundary |=> cycle_o);

  // R3: strobe is one clock wide
  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    cycle_o |=> !cycle_o);

  // R5: reset state
  p_reset_state_r5: assert property (@(posedge clk)
    rst |=> (cnt == '0 && hi_q && !cycle_o));
endmodule

// File: tb/dual_modulus_divider_test.sv
module dual_modulus_divider_test;
  localparam int P = 10;
  localparam int M = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_i = 1'b0;
  logic mode_hi_i = 1'b1;
  logic cycle_o;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  int m_cnt = 0;
  int m_len = P + M;
  int seen = 0;
  bit prev_strobe = 1'b0;
  int cycles = 0;
  bit done = 1'b0;

  dual_modulus_divider #(.P(P), .M(M)) uut (
    .clk(clk), .rst(rst), .pulse_i(pulse_i),
    .mode_hi_i(mode_hi_i), .cycle_o(cycle_o)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one pulse; model the cycle length independently
  task automatic send(input bit mode, input int gap, input string req);
    @(posedge clk); #2;
    pulse_i = 1'b1;
    mode_hi_i = mode;
    m_cnt++;
    if (m_cnt == m_len) begin
      exp_q.push_back(m_len);
      tag_q.push_back(req);
      m_len = mode ? P + M : P;
      m_cnt = 0;
    end
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #2;
      pulse_i = 1'b0;
      mode_hi_i = ~mode;   // R4: idle-clock mode values must be ignored
    end
    if (gap == 0) begin
      @(posedge clk); #2;
      pulse_i = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1;
    pulse_i = 1'b0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    exp_q.delete();
    tag_q.delete();
    m_cnt = 0;
    m_len = P + M;
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      seen = 0;
      prev_strobe = 1'b0;
    end else begin
      if (cycle_o) begin
        check(!prev_strobe, "R3 strobe width", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected strobe", seen, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(seen == e, t, seen, e);
        end
        seen = 0;
      end
      prev_strobe = cycle_o;
      if (pulse_i) seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(cycle_o == 1'b0, "R5 strobe low after reset", cycle_o, 0);

    // R5: first cycle is upper modulus; then R1 with mode low, dense pulses
    for (int i = 0; i < 3 * P + M; i++) send(1'b0, 0, "R1 R5 low mode");
    // R2: mode high with gaps
    for (int i = 0; i < 3 * (P + M); i++) send(1'b1, 2, "R2 R6 high mode gaps");
    // R4: mode toggles on every pulse
    for (int i = 0; i < 8 * (P + M); i++) send(i[0], 0, "R4 toggle per pulse");
    // R6: irregular gaps, mode alternating every 7 pulses
    for (int i = 0; i < 6 * (P + M); i++) send((i / 7) % 2 == 1, i % 4, "R4 R6 irregular");
    repeat (5) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R3 all cycles strobed", exp_q.size(), 0);

    // R7: reset partway through a cycle
    for (int i = 0; i < 5; i++) send(1'b0, 1, "R7 pre-reset");
    do_reset();
    for (int i = 0; i < 2 * (P + M); i++) send(1'b0, 0, "R7 after mid reset");
    repeat (5) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R7 all cycles strobed", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule